// File: doc/BRIEF.md
# Power-Fail Reset Supervisor

This block watches the main supply through three digitised comparator flags: main below the power-fail trip level, main below the backup level, and trip level below the backup level. From these it chooses the rail that feeds the timekeeping logic, blocks register writes while main is failing, and drives an active-high system reset that is held through a recovery interval once main comes back.

When the oscillator-stop control bit was set while main was failing, the oscillator was stopped during the outage. The reset release then also waits for an oscillator-stable indication after the recovery interval. The four comparator and oscillator-stable inputs are resynchronised with two flops. The oscillator-stop bit comes from a register in the same clock domain and is used directly. The recovery interval is a parameter counted in clock cycles.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: Every asynchronous input passes two synchronising flops, so a change on main_lt_fail_i, main_lt_bkp_i or fail_lt_bkp_i shows on wr_block_o and on_backup_o at the third rising clock edge after the change and not before.
- R2: wr_block_o is 1 exactly while the synchronised main-below-trip flag is 1, with the R1 latency.
- R3: With fail_lt_bkp_i = 1, on_backup_o follows main_lt_fail_i.
- R4: With fail_lt_bkp_i = 0, on_backup_o follows main_lt_bkp_i.
- R5: sys_rst_o asserts at the same edge as wr_block_o, and it stays 1 for as long as wr_block_o is 1.
- R6: Once main_lt_fail_i clears, sys_rst_o falls at the (3 + HOLD_CYCLES)-th rising edge after the change, provided the oscillator was not stopped.
- R7: If osc_stop_i was 1 at any edge during the failure, the release also waits for osc_stable_i. It falls at edge 4 + HOLD_CYCLES if osc_stable_i is already 1. Otherwise it falls at the third edge after osc_stable_i rises, once the hold count is done.
- R8: A new failure during the hold-off restarts the sequence. sys_rst_o stays 1 and falls 3 + HOLD_CYCLES edges after the last clear.
- R9: on_backup_o returns to 0 three edges after its switchover condition clears, even while sys_rst_o is still held.
- R10: While rst_n is low, sys_rst_o = 1, wr_block_o = 1 and on_backup_o = 0.
- R11: A 1 on osc_stop_i that is seen only outside a failure has no effect on the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_lt_fail_i | input | 1 | Main supply below the power-fail trip level |
| main_lt_bkp_i | input | 1 | Main supply below the backup level |
| fail_lt_bkp_i | input | 1 | Trip level lies below the backup level |
| osc_stop_i | input | 1 | Oscillator-stop control bit, 1 = stopped while on backup |
| osc_stable_i | input | 1 | Oscillator has started and is stable |
| sys_rst_o | output | 1 | System reset, active high |
| wr_block_o | output | 1 | Register write inhibit |
| on_backup_o | output | 1 | 1 = timekeeping logic fed from the backup rail |

## Verification
The hardest case to reach from the ports is a second failure that lands in the middle of the hold-off count. The bench lets main recover and waits a few cycles so the count is partly done. It then raises the fail flag for two cycles, which is just long enough to pass the synchronisers, and measures the release from the final clear. The oscillator-stretch path is also hard to reach. The bench holds osc_stable_i low well past the normal release point and then measures the exact edge after it rises.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_FAIL = 2'd1,
    ST_HOLD = 2'd2,
    ST_OSCW = 2'd3
  } pfs_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pfs_rail.sv
module pfs_rail (
  input  logic clk,
  input  logic rst_n,
  input  logic main_lt_fail,
  input  logic main_lt_bkp,
  input  logic fail_lt_bkp,
  output logic on_backup,
  output logic wr_block
);
  logic bk_d, bk_q, wb_d, wb_q;

  always_comb begin
    // the lower of the two thresholds decides the switchover point
    bk_d = fail_lt_bkp ? main_lt_fail : main_lt_bkp;
    wb_d = main_lt_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bk_q <= 1'b0;
      wb_q <= 1'b1;
    end else begin
      bk_q <= bk_d;
      wb_q <= wb_d;
    end
  end

  assign on_backup = bk_q;
  assign wr_block  = wb_q;
endmodule

// File: rtl/pfs_seq.sv
module pfs_seq
  import pfs_pkg::*;
#(
  parameter int HOLD_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pf,
  input  logic osc_stop,
  input  logic osc_ok,
  output logic rst_active
);
  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  pfs_state_e st_d, st_q;
  logic [CW-1:0] cnt_d, cnt_q;
  logic stretch_d, stretch_q;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    stretch_d = stretch_q;
    case (st_q)
      ST_FAIL: begin
        stretch_d = stretch_q | osc_stop;
        if (!pf) begin
          st_d  = ST_HOLD;
          cnt_d = '0;
        end
      end
      ST_HOLD: begin
        if (cnt_q == LAST) st_d = stretch_q ? ST_OSCW : ST_RUN;
        else               cnt_d = cnt_q + 1'b1;
      end
      ST_OSCW: begin
        if (osc_ok) st_d = ST_RUN;
      end
      default: ;
    endcase
    if (pf && st_q != ST_FAIL) begin
      st_d      = ST_FAIL;
      stretch_d = osc_stop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_FAIL;
      cnt_q     <= '0;
      stretch_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      stretch_q <= stretch_d;
    end
  end

  assign rst_active = (st_q != ST_RUN);
endmodule

// File: rtl/pwr_fail_supervisor.sv
module pwr_fail_supervisor #(
  parameter int HOLD_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_lt_fail_i,
  input  logic main_lt_bkp_i,
  input  logic fail_lt_bkp_i,
  input  logic osc_stop_i,
  input  logic osc_stable_i,
  output logic sys_rst_o,
  output logic wr_block_o,
  output logic on_backup_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw, synced;

  assign raw = {osc_stable_i, fail_lt_bkp_i, main_lt_bkp_i, main_lt_fail_i};

  pfs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  pfs_rail u_rail (
    .clk          (clk),
    .rst_n        (rst_n),
    .main_lt_fail (synced[0]),
    .main_lt_bkp  (synced[1]),
    .fail_lt_bkp  (synced[2]),
    .on_backup    (on_backup_o),
    .wr_block     (wr_block_o)
  );

  pfs_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pf         (synced[0]),
    .osc_stop   (osc_stop_i),
    .osc_ok     (synced[3]),
    .rst_active (sys_rst_o)
  );
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int HOLD_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic main_lt_fail_i,
  input logic main_lt_bkp_i,
  input logic fail_lt_bkp_i,
  input logic sys_rst_o,
  input logic wr_block_o,
  input logic on_backup_o
);
  logic [1:0] age;
  int unsigned held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 0;
    else if (wr_block_o) held <= 0;
    else if (sys_rst_o) held <= held + 1;
  end

  p_block_implies_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block_o |-> sys_rst_o);

  p_release_unblocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> !wr_block_o);

  p_holdoff_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> held >= HOLD_CYCLES);

  p_rail_low_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && $past(fail_lt_bkp_i, 3)) |-> on_backup_o == $past(main_lt_fail_i, 3));

  p_rail_high_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !$past(fail_lt_bkp_i, 3)) |-> on_backup_o == $past(main_lt_bkp_i, 3));
endmodule

bind pwr_fail_supervisor pfs_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .main_lt_fail_i (main_lt_fail_i),
  .main_lt_bkp_i  (main_lt_bkp_i),
  .fail_lt_bkp_i  (fail_lt_bkp_i),
  .sys_rst_o      (sys_rst_o),
  .wr_block_o     (wr_block_o),
  .on_backup_o    (on_backup_o)
);

// File: tb/pwr_fail_supervisor_bench.sv
module pwr_fail_supervisor_bench;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic mf, mb, fb, ostop, ostab;
  logic sys_rst, wr_block, on_bk;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_fail_supervisor #(.HOLD_CYCLES(N)) u_pwr_fail_supervisor (
    .clk            (clk),
    .rst_n          (rst_n),
    .main_lt_fail_i (mf),
    .main_lt_bkp_i  (mb),
    .fail_lt_bkp_i  (fb),
    .osc_stop_i     (ostop),
    .osc_stable_i   (ostab),
    .sys_rst_o      (sys_rst),
    .wr_block_o     (wr_block),
    .on_backup_o    (on_bk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (sys_rst && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    bit pbk, pwb;
    rst_n = 1'b0; mf = 0; mb = 0; fb = 0; ostop = 0; ostab = 0;
    tick(3);
    // R10 reset values
    chk(sys_rst == 1, "R10 sys_rst", sys_rst, 1);
    chk(wr_block == 1, "R10 wr_block", wr_block, 1);
    chk(on_bk == 0, "R10 on_backup", on_bk, 0);
    rst_n = 1'b1;
    tick(N + 10);
    chk(sys_rst == 0, "R6 release after reset", sys_rst, 0);

    // R1 R2 R3 R4: sweep all flag combinations, in two orders
    pbk = on_bk; pwb = wr_block;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 8; i++) begin
        int k;
        bit ebk, ewb;
        k = pass ? (7 - i) : i;
        mf = k[0]; mb = k[1]; fb = k[2];
        ewb = k[0];
        ebk = k[2] ? k[0] : k[1];
        tick(2);
        chk(on_bk == pbk, "R1 rail not early", on_bk, pbk);
        chk(wr_block == pwb, "R1 block not early", wr_block, pwb);
        tick(1);
        chk(wr_block == ewb, "R2 write block", wr_block, ewb);
        if (k[2]) chk(on_bk == ebk, "R3 rail low trip", on_bk, ebk);
        else      chk(on_bk == ebk, "R4 rail high trip", on_bk, ebk);
        chk(!wr_block || sys_rst, "R5 reset with block", sys_rst, 1);
        pbk = ebk; pwb = ewb;
      end
    end
    mf = 0; mb = 0; fb = 0;
    tick(N + 10);

    // R5 R6 basic recovery
    mf = 1;
    tick(3);
    chk(sys_rst == 1, "R5 reset asserted", sys_rst, 1);
    tick(5);
    mf = 0;
    measure(n);
    chk(n == 3 + N, "R6 hold-off length", n, 3 + N);

    // R9 rail returns independent of hold-off
    fb = 0; mb = 1; mf = 1;
    tick(10);
    chk(on_bk == 1, "R9 on backup", on_bk, 1);
    mb = 0; mf = 0;
    tick(3);
    chk(on_bk == 0, "R9 rail back", on_bk, 0);
    chk(sys_rst == 1, "R9 reset still held", sys_rst, 1);
    tick(N + 5);

    // R7 oscillator already stable
    ostop = 1; ostab = 1; mf = 1;
    tick(10);
    mf = 0;
    measure(n);
    chk(n == 4 + N, "R7 stretch stable osc", n, 4 + N);

    // R7 oscillator becomes stable late
    ostab = 0; mf = 1;
    tick(10);
    ostop = 0;
    mf = 0;
    tick(N + 11);
    chk(sys_rst == 1, "R7 waiting for osc", sys_rst, 1);
    ostab = 1;
    measure(n);
    chk(n == 3, "R7 release after osc", n, 3);

    // R11 stop bit seen only while running
    ostab = 0;
    ostop = 1;
    tick(5);
    ostop = 0;
    mf = 1;
    tick(10);
    mf = 0;
    measure(n);
    chk(n == 3 + N, "R11 stop bit ignored", n, 3 + N);

    // R8 new failure during hold-off
    mf = 1;
    tick(10);
    mf = 0;
    tick(5);
    chk(sys_rst == 1, "R8 in hold-off", sys_rst, 1);
    mf = 1;
    tick(2);
    mf = 0;
    tick(1);
    chk(sys_rst == 1, "R8 still held", sys_rst, 1);
    measure(n);
    chk(n == 2 + N, "R8 restart length", n + 1, 3 + N);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule